// File: doc/BRIEF.md
# Splittable Dual 16/32-bit Down-Counting Timer

This block is a general-purpose timer built from two counter halves, A and B, each `HALF_W` bits wide. Software reaches it through a simple word-addressed register bus. A join bit selects how the halves run. When it is clear, they are two independent timers. When it is set, they form a single counter of twice the width, driven by the controls of half A.

Each half has a 2-bit mode field that selects one-shot or periodic operation, and an interval load register that holds the start value. Setting a run bit copies the load value into the counter. The counter then counts down by one per clock. When it reaches zero, a periodic counter reloads and keeps running. A one-shot counter stops and clears its own run bit.

Every timeout sets a raw status bit, which software clears by writing one to it. A mask register selects which raw bits drive the single interrupt output. Software is expected to clear the run bits before it changes the join bit, a mode or a load value.

Top module: `dual_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The mode field (bits 1:0 at offset 2 for A, offset 3 for B) uses 1 for one-shot and 2 for periodic. Values 0 and 3 block counting: a start write leaves the run bit clear and the counter unchanged.
- R3: Writing 1 to a run bit of the control register (offset 1, bit 0 for A, bit 1 for B) while that half is idle loads its counter with the load value on that edge. The counter then decrements once per clock. The raw bit is set on the edge where a running counter already holds zero, which is L+1 clocks after the start.
- R4: In periodic mode, the timeout edge reloads the counter with the load value, and the half keeps running.
- R5: In one-shot mode, the timeout edge clears the run bit, and the counter holds zero.
- R6: With the join bit clear (offset 0, bit 0), each half uses its own mode field, load register (offsets 4 and 5) and count readback (offsets 6 and 7). Load A then reads back only its low `HALF_W` bits.
- R7: With the join bit set, mode A governs the joined counter, mode B is ignored, and run bit B can never be set.
- R8: With the join bit set, load A (offset 4) is read and written at full double width, and its upper half is the storage of load B. Count A (offset 6) reads the joined counter, which borrows across the halves.
- R9: With the join bit set, writes to load B (offset 5) are dropped.
- R10: The raw status register (offset 8, bit 0 A, bit 1 B) is cleared per bit by writing 1 to offset 11. In joined operation, only bit 0 is set by timeouts.
- R11: `irq` is high exactly when some raw bit is set and its bit in the mask register (offset 9) is set. Offset 10 reads the masked status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Word offset of the register |
| bus_wdata | input | 2*HALF_W | Write data |
| bus_rdata | output | 2*HALF_W | Combinational read data for bus_addr |
| irq | output | 1 | Masked timeout interrupt |

## Verification
The bench builds the block with `HALF_W` = 8, which makes the bus 16 bits wide. At that width, a joined interval of a few hundred clocks is enough to show the borrow from the low half into the high half and a full periodic reload within a short run. Random one-shot and periodic runs on both halves include a zero interval, which fires on every clock. Directed cases cover the dropped writes, the ignored mode and run bits in joined operation, and the blocked modes 0 and 3.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [3:0]            bus_addr,
  input  logic [2*HALF_W-1:0]   bus_wdata,
  output logic [2*HALF_W-1:0]   bus_rdata,
  output logic                  irq
);
  localparam int FULL_W = 2 * HALF_W;
  localparam logic [1:0] M_ONE = 2'd1;
  localparam logic [1:0] M_PER = 2'd2;
  localparam logic [3:0] A_CFG = 4'd0, A_CTL = 4'd1, A_MDA = 4'd2, A_MDB = 4'd3,
                         A_LDA = 4'd4, A_LDB = 4'd5, A_CNA = 4'd6, A_CNB = 4'd7,
                         A_RAW = 4'd8, A_MSK = 4'd9, A_MST = 4'd10, A_CLR = 4'd11;

  logic              join_q;
  logic [1:0]        run_q, raw_q, mask_q;
  logic [1:0]        mode_a, mode_b;
  logic [HALF_W-1:0] load_a, load_b, cnt_a, cnt_b;

  wire              wr      = bus_sel && bus_wr;
  wire              wr_ctl  = wr && bus_addr == A_CTL;
  wire [1:0]        mode_be = join_q ? mode_a : mode_b;
  wire              ok_a    = (mode_a == M_ONE) || (mode_a == M_PER);
  wire              ok_b    = (mode_be == M_ONE) || (mode_be == M_PER);
  wire [FULL_W-1:0] cnt_f   = {cnt_b, cnt_a};
  wire [FULL_W-1:0] cnt_fm1 = cnt_f - 1'b1;
  wire              zero_a  = join_q ? (cnt_f == '0) : (cnt_a == '0);
  wire              tick_a  = run_q[0] && ok_a;
  wire              tick_b  = run_q[1] && ok_b && !join_q;
  wire              hit_a   = tick_a && zero_a;
  wire              hit_b   = tick_b && (cnt_b == '0);
  wire [1:0]        mstat   = raw_q & mask_q;

  assign irq = |mstat;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: bus_rdata[0]   = join_q;
      A_CTL: bus_rdata[1:0] = run_q;
      A_MDA: bus_rdata[1:0] = mode_a;
      A_MDB: bus_rdata[1:0] = mode_b;
      A_LDA: bus_rdata      = join_q ? {load_b, load_a} : {{HALF_W{1'b0}}, load_a};
      A_LDB: bus_rdata[HALF_W-1:0] = load_b;
      A_CNA: bus_rdata      = join_q ? cnt_f : {{HALF_W{1'b0}}, cnt_a};
      A_CNB: bus_rdata[HALF_W-1:0] = cnt_b;
      A_RAW: bus_rdata[1:0] = raw_q;
      A_MSK: bus_rdata[1:0] = mask_q;
      A_MST: bus_rdata[1:0] = mstat;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      join_q <= 1'b0;
      run_q  <= '0;
      raw_q  <= '0;
      mask_q <= '0;
      mode_a <= '0;
      mode_b <= '0;
      load_a <= '0;
      load_b <= '0;
      cnt_a  <= '0;
      cnt_b  <= '0;
    end else begin
      if (wr && bus_addr == A_CFG) join_q <= bus_wdata[0];
      if (wr && bus_addr == A_MDA) mode_a <= bus_wdata[1:0];
      if (wr && bus_addr == A_MDB) mode_b <= bus_wdata[1:0];
      if (wr && bus_addr == A_MSK) mask_q <= bus_wdata[1:0];
      if (wr && bus_addr == A_LDA) begin
        load_a <= bus_wdata[HALF_W-1:0];
        if (join_q) load_b <= bus_wdata[FULL_W-1:HALF_W];
      end
      if (wr && bus_addr == A_LDB && !join_q) load_b <= bus_wdata[HALF_W-1:0];

      if (wr_ctl && bus_wdata[0] && !run_q[0]) begin
        if (ok_a) begin
          run_q[0] <= 1'b1;
          cnt_a    <= load_a;
          if (join_q) cnt_b <= load_b;
        end
      end else if (wr_ctl && !bus_wdata[0]) begin
        run_q[0] <= 1'b0;
      end else if (tick_a) begin
        if (zero_a) begin
          if (mode_a == M_PER) begin
            cnt_a <= load_a;
            if (join_q) cnt_b <= load_b;
          end else begin
            run_q[0] <= 1'b0;
          end
        end else if (join_q) begin
          {cnt_b, cnt_a} <= cnt_fm1;
        end else begin
          cnt_a <= cnt_a - 1'b1;
        end
      end

      if (wr_ctl && bus_wdata[1] && !run_q[1]) begin
        if (ok_b && !join_q) begin
          run_q[1] <= 1'b1;
          cnt_b    <= load_b;
        end
      end else if (wr_ctl && !bus_wdata[1]) begin
        run_q[1] <= 1'b0;
      end else if (tick_b) begin
        if (cnt_b == '0) begin
          if (mode_b == M_PER) cnt_b <= load_b;
          else                 run_q[1] <= 1'b0;
        end else begin
          cnt_b <= cnt_b - 1'b1;
        end
      end

      if (wr && bus_addr == A_CLR) raw_q <= raw_q & ~bus_wdata[1:0];
      if (hit_a) raw_q[0] <= 1'b1;
      if (hit_b) raw_q[1] <= 1'b1;
    end
  end

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a && mode_a == M_ONE && !wr |=> !run_q[0] && zero_a); // R5

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a && mode_a == M_PER && !join_q && !wr |=> run_q[0] && cnt_a == $past(load_a)); // R4

  AST_BAD_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_a && !wr |=> $stable(cnt_a) && $stable(run_q[0])); // R2

  AST_JOIN_LOADB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    join_q && wr && bus_addr == A_LDB |=> $stable(load_b)); // R9

  AST_JOIN_NO_RUN_B: assert property (@(posedge clk) disable iff (!rst_n)
    join_q && !run_q[1] |=> !run_q[1]); // R7

  AST_RAW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == A_CLR && bus_wdata[0] && !hit_a |=> !raw_q[0]); // R10

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a && mask_q[0] && !wr |=> irq); // R11
endmodule

// File: tb/test_dual_timer.sv
`timescale 1ns/1ps
module test_dual_timer;
  localparam int HW = 8;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [FW-1:0] bus_wdata = '0;
  logic [FW-1:0] bus_rdata;
  logic irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_timer #(.HALF_W(HW)) i_dual_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [FW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [FW-1:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  function automatic logic [FW-1:0] exp_cnt_after(input bit periodic, input int load);
    return periodic ? FW'(load) : '0;
  endfunction

  function automatic logic [FW-1:0] exp_run_after(input bit periodic, input int h);
    return periodic ? FW'(1 << h) : '0;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] d;
    int seed;
    seed = 11;
    void'($urandom(seed));
    #12 rst_n = 1'b1;
    wait_edges(1);

    for (int a = 0; a < 12; a++) begin
      rd_reg(4'(a), d);
      chk("R1 reset reg", d, 0);
    end
    chk("R1 reset irq", irq, 0);

    wr_reg(4'd2, 16'd1);
    wr_reg(4'd4, 16'd5);
    wr_reg(4'd1, 16'd1);
    wait_edges(2);
    rd_reg(4'd6, d); chk("R3 count down", d, 3);
    wait_edges(3);
    rd_reg(4'd6, d); chk("R3 at zero", d, 0);
    rd_reg(4'd8, d); chk("R3 no early timeout", d, 0);
    wait_edges(1);
    rd_reg(4'd8, d); chk("R3 timeout at L+1", d, 1);
    rd_reg(4'd1, d); chk("R5 run cleared", d, 0);
    wait_edges(3);
    rd_reg(4'd6, d); chk("R5 holds zero", d, 0);
    wr_reg(4'd11, 16'd1);
    rd_reg(4'd8, d); chk("R10 clear", d, 0);

    wr_reg(4'd3, 16'd2);
    wr_reg(4'd5, 16'd3);
    wr_reg(4'd1, 16'd2);
    wait_edges(4);
    rd_reg(4'd8, d); chk("R4 B timeout", d, 2);
    rd_reg(4'd7, d); chk("R4 B reload", d, 3);
    rd_reg(4'd1, d); chk("R6 B still runs", d, 2);
    rd_reg(4'd4, d); chk("R6 load A own", d, 5);
    wait_edges(4);
    rd_reg(4'd7, d); chk("R4 second reload", d, 3);
    wr_reg(4'd1, 16'd0);

    chk("R11 masked off", irq, 0);
    wr_reg(4'd9, 16'd2);
    chk("R11 irq on", irq, 1);
    rd_reg(4'd10, d); chk("R11 masked status", d, 2);
    wr_reg(4'd11, 16'd3);
    chk("R11 irq after clear", irq, 0);

    wr_reg(4'd2, 16'd0);
    wr_reg(4'd1, 16'd1);
    rd_reg(4'd1, d); chk("R2 mode 0 blocks", d, 0);
    wr_reg(4'd2, 16'd3);
    wr_reg(4'd1, 16'd1);
    wait_edges(2);
    rd_reg(4'd1, d); chk("R2 mode 3 blocks", d, 0);
    rd_reg(4'd6, d); chk("R2 count unchanged", d, 0);

    wr_reg(4'd0, 16'd1);
    wr_reg(4'd4, 16'h0123);
    rd_reg(4'd4, d); chk("R8 wide load", d, 16'h0123);
    rd_reg(4'd5, d); chk("R8 shared upper", d, 16'h01);
    wr_reg(4'd5, 16'h55);
    rd_reg(4'd4, d); chk("R9 B write dropped", d, 16'h0123);
    wr_reg(4'd2, 16'd2);
    wr_reg(4'd3, 16'd1);
    wr_reg(4'd4, 16'h0104);
    wr_reg(4'd1, 16'd3);
    rd_reg(4'd1, d); chk("R7 run B ignored", d, 1);
    wait_edges(5);
    rd_reg(4'd6, d); chk("R8 borrow", d, 16'h00FF);
    wait_edges(255);
    rd_reg(4'd8, d); chk("R3 joined no early", d, 0);
    wait_edges(1);
    rd_reg(4'd8, d); chk("R10 joined bit0 only", d, 1);
    rd_reg(4'd6, d); chk("R7 mode A periodic", d, 16'h0104);
    rd_reg(4'd1, d); chk("R7 still running", d, 1);
    wr_reg(4'd1, 16'd0);
    wr_reg(4'd11, 16'd3);
    wr_reg(4'd0, 16'd0);

    for (int k = 0; k < 24; k++) begin
      int h, ld;
      bit per;
      h   = int'($urandom_range(1, 0));
      per = bit'($urandom_range(1, 0));
      ld  = int'($urandom_range(15, 0));
      wr_reg(4'(2 + h), per ? 16'd2 : 16'd1);
      wr_reg(4'(4 + h), 16'(ld));
      wr_reg(4'd1, 16'(1 << h));
      wait_edges(ld);
      rd_reg(4'd8, d); chk("R3 random no early", d, 0);
      wait_edges(1);
      rd_reg(4'd8, d); chk("R6 random timeout", d, 16'(1 << h));
      rd_reg(4'(6 + h), d); chk(per ? "R4 random reload" : "R5 random hold", d, exp_cnt_after(per, ld));
      rd_reg(4'd1, d); chk(per ? "R4 random run" : "R5 random stop", d, exp_run_after(per, h));
      wr_reg(4'd1, 16'd0);
      wr_reg(4'd11, 16'd3);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule